// File: doc/BRIEF.md
# Snooping MSI Cache-Line Controller

This block keeps one private, direct-mapped, one-word-per-line cache coherent with its peers on a shared snooping bus. Each line is Invalid, Shared (read-only) or Modified (sole writable copy). Processor reads and writes that hit are served in the same cycle. Misses, upgrades and victim write-backs first win the shared bus and then hold it for the whole tenure. This serialises writes to a location and keeps two caches from racing on it.

In parallel, the controller watches the transactions that other caches put on the bus. A snooped miss that hits a Modified line is answered from this cache: the line's data is driven as supplied data, the memory read is aborted, and the block is written back to memory. The line then drops to Shared after a read miss, or to Invalid after a write miss or an invalidate. A snooped write miss or invalidate simply drops a Shared line.

The address is split as index = low log2(LINES) bits and tag = the remaining high bits. Bus commands use a 2-bit code: 0 read miss, 1 write miss, 2 invalidate, 3 write-back.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid; with no request pending, bus_req, cpu_ready, snp_sup and mem_we are all low, and the first read of any address misses.
- R2: A read that misses (line Invalid, or valid with another tag and not Modified) issues exactly one bus command 0 at the request address, returns the memory word, and leaves the line Shared.
- R3: A read hitting a Shared or Modified line, or a write hitting a Modified line, completes with cpu_ready in the cycle the request is presented and produces no bus command.
- R4: A write hitting a Shared line issues exactly one bus command 2 (invalidate) at the request address, after which the line is Modified and later writes to it hit.
- R5: A write that misses issues exactly one bus command 1 at the request address and leaves the line Modified holding the written word.
- R6: A miss whose line is Modified with another tag first issues bus command 3 at the old address, with a memory write of the old word, and then issues the miss command in the next granted cycle without releasing bus_req.
- R7: A snooped command 0 matching a Modified line raises snp_sup with the line's word on snp_data, writes that word to memory at the snooped address, and downgrades the line to Shared, so that a later local write sends command 2.
- R8: A snooped command 1 or 2 matching a line invalidates it. A Shared line gives no supply and no memory write. A Modified line first supplies its word and writes it back to memory.
- R9: A snooped command 0 matching a Shared line, or matching no line, drives no supply and no memory write and leaves the line in place.
- R10: bus_req rises the cycle after a miss is presented and stays high until the request completes. Bus commands appear only in cycles where bus_gnt is high, one command per cycle.
- R11: If a waiting write's Shared line is invalidated by a snoop before the grant arrives, the write is issued as command 1, not command 2.
- R12: When bus_sup_valid is high during this cache's own miss, the line is filled from bus_sup_data and mem_re stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request pending, held until cpu_ready |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | This cache drives a command this cycle |
| bus_cmd | output | 2 | 0 read miss, 1 write miss, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Command address |
| bus_sup_valid | input | 1 | A peer supplies the block for this cache's miss |
| bus_sup_data | input | DATA_W | Word supplied by the peer |
| snp_valid | input | 1 | A peer's command is on the bus |
| snp_cmd | input | 2 | Peer command code |
| snp_addr | input | ADDR_W | Peer command address |
| snp_sup | output | 1 | This cache supplies the snooped block |
| snp_data | output | DATA_W | Supplied word |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write (victim or snoop write-back) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |

## Verification
The bench builds the controller with ADDR_W=6, DATA_W=8 and LINES=4, so the whole 64-word address space can be swept. Every index is then reused sixteen times with distinct tags, which brings all conflict misses within reach. With only four lines, each snoop case (Shared, Modified, no match, read, write, invalidate) can be placed on a line whose state the bench knows. A late grant puts the snoop-before-grant retry and bus-hold behaviour in view. The bench memory's contents come from a simple arithmetic formula, so each expected fill is computed directly.

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sup_valid,
  input  logic [DATA_W-1:0] bus_sup_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_sup,
  output logic [DATA_W-1:0] snp_data,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] CMD_RD = 2'd0;
  localparam logic [1:0] CMD_WR = 2'd1;
  localparam logic [1:0] CMD_INV = 2'd2;
  localparam logic [1:0] CMD_WB = 2'd3;

  typedef enum logic [1:0] {LN_I, LN_S, LN_M} line_t;

  line_t             st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic              busy_q;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  line_t            c_st;
  logic             c_tagm, c_hit, fast_hit, fast_ok, miss_go;
  logic             s_hit, s_mod, own, victim_wb, done_bus;
  logic [1:0]       op_cmd;
  logic [DATA_W-1:0] fill;

  assign c_idx  = cpu_addr[IDX_W-1:0];
  assign c_tag  = cpu_addr[ADDR_W-1:IDX_W];
  assign c_st   = st_q[c_idx];
  assign c_tagm = tag_q[c_idx] == c_tag;
  assign c_hit  = (c_st != LN_I) && c_tagm;
  assign fast_hit = c_hit && (!cpu_we || c_st == LN_M);

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_hit = snp_valid && (snp_cmd != CMD_WB) && (st_q[s_idx] != LN_I) && (tag_q[s_idx] == s_tag);
  assign s_mod = s_hit && (st_q[s_idx] == LN_M);

  assign fast_ok = cpu_valid && !busy_q && fast_hit && !(s_hit && s_idx == c_idx);
  assign miss_go = cpu_valid && !busy_q && !fast_hit;

  assign own       = busy_q && bus_gnt;
  assign victim_wb = own && (c_st == LN_M) && !c_tagm;
  assign done_bus  = own && !victim_wb;

  always_comb begin
    if (victim_wb)                         op_cmd = CMD_WB;
    else if (!cpu_we)                      op_cmd = CMD_RD;
    else if (c_hit && c_st == LN_S)        op_cmd = CMD_INV;
    else                                   op_cmd = CMD_WR;
  end

  assign fill      = bus_sup_valid ? bus_sup_data : mem_rdata;
  assign cpu_ready = fast_ok || done_bus;
  assign cpu_rdata = done_bus ? fill : dat_q[c_idx];

  assign bus_req   = busy_q;
  assign bus_valid = own;
  assign bus_cmd   = op_cmd;
  assign bus_addr  = victim_wb ? {tag_q[c_idx], c_idx} : cpu_addr;

  assign snp_sup  = s_mod;
  assign snp_data = dat_q[s_idx];

  assign mem_re    = done_bus && (op_cmd != CMD_INV) && !bus_sup_valid;
  assign mem_we    = victim_wb || s_mod;
  assign mem_addr  = s_mod ? snp_addr : bus_addr;
  assign mem_wdata = s_mod ? dat_q[s_idx] : dat_q[c_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_I;
    end else begin
      if (miss_go)       busy_q <= 1'b1;
      else if (done_bus) busy_q <= 1'b0;
      if (s_hit && (snp_cmd != CMD_RD || s_mod))
        st_q[s_idx] <= (snp_cmd == CMD_RD) ? LN_S : LN_I;
      if (victim_wb) st_q[c_idx] <= LN_I;
      if (done_bus)  st_q[c_idx] <= cpu_we ? LN_M : LN_S;
    end
  end

  always_ff @(posedge clk) begin
    if (done_bus) begin
      tag_q[c_idx] <= c_tag;
      dat_q[c_idx] <= cpu_we ? cpu_wdata : fill;
    end else if (fast_ok && cpu_we) begin
      dat_q[c_idx] <= cpu_wdata;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cpu_ready) |=> bus_req);
  assert_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_gnt && bus_req));
  assert_rd_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_we) |=>
      (st_q[$past(c_idx)] != LN_I) && (tag_q[$past(c_idx)] == $past(c_tag)));
  assert_wr_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_we) |=>
      (st_q[$past(c_idx)] == LN_M) && (dat_q[$past(c_idx)] == $past(cpu_wdata)));
  assert_snp_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_cmd != CMD_RD && !cpu_ready) |=> st_q[$past(s_idx)] == LN_I);
  assert_snp_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mod && snp_cmd == CMD_RD && !cpu_ready) |=> st_q[$past(s_idx)] == LN_S);
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sup_valid |-> !mem_re);
  assert_mem_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

// File: tb/msi_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module msi_snoop_cache_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_we = 0;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [7:0] cpu_rdata;
  logic bus_req, bus_gnt = 0, bus_valid;
  logic [1:0] bus_cmd;
  logic [5:0] bus_addr;
  logic bus_sup_valid = 0;
  logic [7:0] bus_sup_data = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [5:0] snp_addr = '0;
  logic snp_sup;
  logic [7:0] snp_data;
  logic mem_re, mem_we;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [64];

  int nchk = 0, nbad = 0, nlog = 0;
  bit req_gap;
  logic [1:0] lg_cmd [4];
  logic [5:0] lg_addr [4];
  logic lg_mwe [4], lg_mre [4];
  logic [7:0] lg_mwd [4];

  always #4 clk = ~clk;

  msi_snoop_cache #(.ADDR_W(6), .DATA_W(8), .LINES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_sup_valid(bus_sup_valid), .bus_sup_data(bus_sup_data), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_sup(snp_sup), .snp_data(snp_data),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  function automatic logic [7:0] f(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = f(i);
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input int a, input logic [7:0] d, input int gdly,
                        input bit sup, input logic [7:0] sd, input int snp_at, input int snp_a,
                        output logic [7:0] rd);
    int cyc;
    bit seen;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = 6'(a); cpu_wdata = d;
    nlog = 0; req_gap = 0; seen = 0; cyc = 0; rd = 'x;
    forever begin
      if (cyc == snp_at) begin snp_valid = 1; snp_cmd = 2'd2; snp_addr = 6'(snp_a); end
      #1;
      bus_gnt = bus_req && (cyc >= gdly);
      bus_sup_valid = sup && bus_gnt; bus_sup_data = sd;
      #1;
      if (bus_req) seen = 1; else if (seen) req_gap = 1;
      if (bus_valid && nlog < 4) begin
        lg_cmd[nlog] = bus_cmd; lg_addr[nlog] = bus_addr; lg_mwe[nlog] = mem_we;
        lg_mre[nlog] = mem_re; lg_mwd[nlog] = mem_wdata; nlog++;
      end
      if (cpu_ready) begin rd = cpu_rdata; break; end
      if (cyc > 50) break;
      @(negedge clk); snp_valid = 0; cyc++;
    end
    @(negedge clk);
    cpu_valid = 0; bus_gnt = 0; bus_sup_valid = 0; snp_valid = 0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input int a, output logic sup, output logic [7:0] sd,
                       output logic mwe, output logic [5:0] maddr, output logic [7:0] mwd);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = 6'(a);
    #1;
    sup = snp_sup; sd = snp_data; mwe = mem_we; maddr = mem_addr; mwd = mem_wdata;
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] rd, sd, mwd;
    logic sup, mwe;
    logic [5:0] maddr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 bus_req idle", bus_req, 0);
    chk("R1 cpu_ready idle", cpu_ready, 0);
    chk("R1 snp_sup idle", snp_sup, 0);
    chk("R1 mem_we idle", mem_we, 0);

    for (int a = 0; a < 64; a++) begin
      cpu_op(0, a, 0, a % 3, 0, 0, -1, 0, rd);
      chk("R1 R2 sweep miss count", nlog, 1);
      chk("R2 sweep cmd", lg_cmd[0], 0);
      chk("R2 sweep addr", lg_addr[0], a);
      chk("R2 sweep data", rd, f(a));
      chk("R10 sweep req held", req_gap, 0);
    end

    for (int a = 60; a < 64; a++) begin
      cpu_op(0, a, 0, 0, 0, 0, -1, 0, rd);
      chk("R3 read hit no bus", nlog, 0);
      chk("R3 read hit data", rd, f(a));
    end

    cpu_op(1, 61, 8'hA1, 2, 0, 0, -1, 0, rd);
    chk("R4 upgrade count", nlog, 1);
    chk("R4 upgrade cmd", lg_cmd[0], 2);
    chk("R4 upgrade addr", lg_addr[0], 61);
    chk("R10 upgrade req held", req_gap, 0);
    cpu_op(1, 61, 8'hA2, 0, 0, 0, -1, 0, rd);
    chk("R3 write hit no bus", nlog, 0);
    cpu_op(0, 61, 0, 0, 0, 0, -1, 0, rd);
    chk("R3 read after write hit", rd, 8'hA2);

    cpu_op(0, 1, 0, 1, 0, 0, -1, 0, rd);
    chk("R6 two ops", nlog, 2);
    chk("R6 wb cmd", lg_cmd[0], 3);
    chk("R6 wb addr", lg_addr[0], 61);
    chk("R6 wb mem write", lg_mwe[0], 1);
    chk("R6 wb data", lg_mwd[0], 8'hA2);
    chk("R6 miss cmd", lg_cmd[1], 0);
    chk("R6 miss addr", lg_addr[1], 1);
    chk("R6 fill data", rd, f(1));
    chk("R12 normal fill reads memory", lg_mre[1], 1);
    chk("R10 wb tenure held", req_gap, 0);
    chk("R6 memory updated", mem[61], 8'hA2);

    cpu_op(1, 2, 8'hB5, 0, 0, 0, -1, 0, rd);
    chk("R5 wr miss count", nlog, 1);
    chk("R5 wr miss cmd", lg_cmd[0], 1);
    chk("R5 wr miss addr", lg_addr[0], 2);
    cpu_op(0, 2, 0, 0, 0, 0, -1, 0, rd);
    chk("R5 line modified hit", nlog, 0);
    chk("R5 written word", rd, 8'hB5);

    snoop(2'd1, 60, sup, sd, mwe, maddr, mwd);
    chk("R8 shared no supply", sup, 0);
    chk("R8 shared no mem write", mwe, 0);
    cpu_op(1, 60, 8'hC3, 0, 0, 0, -1, 0, rd);
    chk("R8 R5 invalidated write miss cmd", lg_cmd[0], 1);
    chk("R8 R5 invalidated write miss addr", lg_addr[0], 60);

    snoop(2'd0, 2, sup, sd, mwe, maddr, mwd);
    chk("R7 supply", sup, 1);
    chk("R7 supply data", sd, 8'hB5);
    chk("R7 mem write", mwe, 1);
    chk("R7 mem addr", maddr, 2);
    chk("R7 mem data", mwd, 8'hB5);
    chk("R7 memory updated", mem[2], 8'hB5);
    cpu_op(1, 2, 8'hD7, 0, 0, 0, -1, 0, rd);
    chk("R7 downgraded to shared count", nlog, 1);
    chk("R7 downgraded to shared cmd", lg_cmd[0], 2);

    snoop(2'd2, 2, sup, sd, mwe, maddr, mwd);
    chk("R8 modified supply", sup, 1);
    chk("R8 modified data", sd, 8'hD7);
    chk("R8 modified wb", mwe, 1);
    chk("R8 modified wb addr", maddr, 2);
    cpu_op(0, 2, 0, 0, 0, 0, -1, 0, rd);
    chk("R8 line invalid count", nlog, 1);
    chk("R8 line invalid cmd", lg_cmd[0], 0);
    chk("R8 refetched data", rd, 8'hD7);

    snoop(2'd0, 1, sup, sd, mwe, maddr, mwd);
    chk("R9 shared read no supply", sup, 0);
    chk("R9 shared read no wb", mwe, 0);
    snoop(2'd0, 5, sup, sd, mwe, maddr, mwd);
    chk("R9 nomatch no supply", sup, 0);
    chk("R9 nomatch no wb", mwe, 0);
    snoop(2'd2, 9, sup, sd, mwe, maddr, mwd);
    chk("R9 nomatch inval no supply", sup, 0);
    cpu_op(0, 1, 0, 0, 0, 0, -1, 0, rd);
    chk("R9 line kept", nlog, 0);
    chk("R9 line data", rd, f(1));

    cpu_op(1, 63, 8'hE9, 3, 0, 0, 1, 63, rd);
    chk("R11 retry count", nlog, 1);
    chk("R11 retry cmd", lg_cmd[0], 1);
    chk("R11 retry addr", lg_addr[0], 63);
    chk("R10 wait req held", req_gap, 0);
    cpu_op(0, 63, 0, 0, 0, 0, -1, 0, rd);
    chk("R11 retry result", rd, 8'hE9);

    cpu_op(0, 13, 0, 0, 1, 8'h5C, -1, 0, rd);
    chk("R12 count", nlog, 1);
    chk("R12 cmd", lg_cmd[0], 0);
    chk("R12 mem read aborted", lg_mre[0], 0);
    chk("R12 supplied data", rd, 8'h5C);
    cpu_op(0, 13, 0, 0, 0, 0, -1, 0, rd);
    chk("R12 supplied data kept", rd, 8'h5C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule